// File: doc/BRIEF.md
# Multi-Copy Bitwise Consensus Voter with Erasure Marking

This block merges several noisy copies of the same 120-bit payload into one consensus word. Copies are streamed in four at a time on a 512-bit bus, each copy sitting in its own 128-bit lane. Four accepted beats make one vote round, so up to sixteen copy slots feed each result. For every payload bit position an independent voting cell counts the ones across all slots of the round. It then decides the consensus bit by comparing twice that count with the number of copies that really exist for the reference.

The number of copies per reference is read from a count memory. Each 64-bit memory word holds sixteen 4-bit counts. The block walks through the fields of a word with a shift register and asks for the next word once every sixteen rounds. Bit positions where ones and zeros are equally common are flagged in an erasure mask, and so is every position of a reference that has no copies. A decoder further down the chain can then treat those bits as unknown rather than wrong.

Top module: `consensus_voter`

## Requirements
- R1: Copy slot `4*b+k` of a round is taken from bits `[128*k +: 120]` of the beat `b` (b, k in 0..3) that the block accepts. Bits 120..127 of every lane have no effect on any output.
- R2: A round is four accepted beats (`inValid` high). Idle cycles between beats pause the round and lose nothing. `outValid` is high for exactly one cycle, in the cycle after the fourth beat is accepted, once per round.
- R3: With copy count c ≥ 1 and n ones at a bit position across the round, `outCons` at that bit is 1 when 2n > c and 0 otherwise. Slots at or above c are zero-filled by the supplier.
- R4: With c ≥ 1, the `outErase` bit is 1 exactly when 2n = c, and the `outCons` bit is then 0.
- R5: With c = 0, all 120 `outErase` bits are 1.
- R6: Round r (counting from 0 after reset) uses the count in bits `[4*(r mod 16) +: 4]` of memory word `r/16`. `cntRdAddr` is 0 after reset and rises by one at the first beat of every round whose number is a multiple of 16. The memory returns the data one cycle after the address. The first beat comes at least two cycles after reset is released.
- R7: The ones count starts from zero in every round. Nothing from an earlier round carries over.
- R8: After reset `outValid` is 0, `outCons` and `outErase` are all zero, and `cntRdAddr` is 0.
- R9: `outCons` and `outErase` hold their values in every cycle in which `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Beat on `inData` is accepted this cycle |
| inData | input | 512 | Four copy lanes of 128 bits, 120 used |
| cntRdData | input | 64 | Count memory read data, sixteen 4-bit counts |
| cntRdAddr | output | 10 | Count memory word address |
| outValid | output | 1 | One-cycle pulse when a round result is presented |
| outCons | output | 120 | Consensus payload |
| outErase | output | 120 | Erasure mask, 1 marks an unreliable bit |

## Verification
The case hardest to reach from the ports is a round that begins a new count word. At that point the count has to come straight from the memory port rather than the shift register, and the prefetched address has to be ready. Reaching it takes sixteen complete rounds per word. The stimulus therefore runs forty rounds over three words, with a count pattern that differs in each field, and inserts pauses at varied points inside rounds. A round in which every bit is an exact tie, a round with no copies, and a zero round directly after an all-ones round bring about the erasure and clearing corner cases.

// File: rtl/mv_pkg.sv
package mv_pkg;
  localparam int CNT_W = 4;

  typedef struct packed {
    logic             en;
    logic             first;
    logic             last;
    logic [CNT_W-1:0] cnt;
  } voteCtl_t;
endpackage

// File: rtl/mv_ctrl.sv
module mv_ctrl
  import mv_pkg::*;
#(
  parameter int BEATS      = 4,
  parameter int CNT_WORD_W = 64,
  parameter int ADDR_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  inValid,
  input  logic [CNT_WORD_W-1:0] cntRdData,
  output logic [ADDR_W-1:0]     cntRdAddr,
  output voteCtl_t              ctl
);
  localparam int FIELDS  = CNT_WORD_W / CNT_W;
  localparam int BEAT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int FIELD_W = (FIELDS > 1) ? $clog2(FIELDS) : 1;

  logic [BEAT_W-1:0]     beatIdx;
  logic [FIELD_W-1:0]    fieldIdx;
  logic [CNT_WORD_W-1:0] cntShift;
  logic [CNT_W-1:0]      curCnt;
  logic                  isFirst, isLast, wordStart;

  assign isFirst   = (beatIdx == '0);
  assign isLast    = (beatIdx == BEAT_W'(BEATS - 1));
  assign wordStart = (fieldIdx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beatIdx   <= '0;
      fieldIdx  <= '0;
      cntShift  <= '0;
      curCnt    <= '0;
      cntRdAddr <= '0;
    end else if (inValid) begin
      beatIdx <= isLast ? '0 : beatIdx + 1'b1;
      if (isFirst) begin
        if (wordStart) begin
          curCnt    <= cntRdData[CNT_W-1:0];
          cntShift  <= cntRdData >> CNT_W;
          cntRdAddr <= cntRdAddr + 1'b1;
        end else begin
          curCnt   <= cntShift[CNT_W-1:0];
          cntShift <= cntShift >> CNT_W;
        end
      end
      if (isLast) begin
        fieldIdx <= (fieldIdx == FIELD_W'(FIELDS - 1)) ? '0 : fieldIdx + 1'b1;
      end
    end
  end

  assign ctl.en    = inValid;
  assign ctl.first = isFirst;
  assign ctl.last  = isLast;
  assign ctl.cnt   = curCnt;

  // Address only ever moves forward by one word.
  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cntRdAddr) |-> cntRdAddr == ADDR_W'($past(cntRdAddr) + 1'b1));

  // First round of a word takes its count straight from the memory port.
  p_cnt_from_port_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && isFirst && wordStart) |=> curCnt == $past(cntRdData[CNT_W-1:0]));
endmodule

// File: rtl/mv_bitcell.sv
module mv_bitcell
  import mv_pkg::*;
#(
  parameter int LANES = 4,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] laneBits,
  input  voteCtl_t         ctl,
  output logic             cons,
  output logic             erase
);
  localparam int ONES_W = $clog2(LANES + 1);
  localparam int ACC_W  = $clog2(LANES * BEATS + 1);
  localparam int DBL_W  = (ACC_W + 1 > CNT_W) ? ACC_W + 1 : CNT_W;

  logic [ONES_W-1:0] beatOnes;
  logic [ACC_W-1:0]  acc, total;
  logic [DBL_W-1:0]  dbl, cntExt;

  always_comb begin
    beatOnes = '0;
    for (int k = 0; k < LANES; k++) beatOnes = beatOnes + ONES_W'(laneBits[k]);
  end

  assign total  = (ctl.first ? '0 : acc) + ACC_W'(beatOnes);
  assign dbl    = DBL_W'({total, 1'b0});
  assign cntExt = DBL_W'(ctl.cnt);
  assign cons   = dbl > cntExt;
  assign erase  = (ctl.cnt == '0) || (dbl == cntExt);

  always_ff @(posedge clk) begin
    if (!rst_n)      acc <= '0;
    else if (ctl.en) acc <= total;
  end
endmodule

// File: rtl/mv_datapath.sv
module mv_datapath
  import mv_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 128,
  parameter int PAY_W  = 120,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [LANES*LANE_W-1:0] inData,
  input  voteCtl_t                ctl,
  output logic                    outValid,
  output logic [PAY_W-1:0]        outCons,
  output logic [PAY_W-1:0]        outErase
);
  logic [PAY_W-1:0] bitCons, bitErase;

  for (genvar i = 0; i < PAY_W; i++) begin : g_cell
    logic [LANES-1:0] column;
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign column[k] = inData[k*LANE_W + i];
    end
    mv_bitcell #(.LANES(LANES), .BEATS(BEATS)) u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .laneBits(column),
      .ctl     (ctl),
      .cons    (bitCons[i]),
      .erase   (bitErase[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outCons  <= '0;
      outErase <= '0;
    end else begin
      outValid <= ctl.en && ctl.last;
      if (ctl.en && ctl.last) begin
        outCons  <= bitCons;
        outErase <= bitErase;
      end
    end
  end

  p_zero_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && ctl.last && ctl.cnt == '0) |=> (&outErase));

  p_tie_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && ctl.last && ctl.cnt != '0) |=> ((outCons & outErase) == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> ($stable(outCons) && $stable(outErase)));
endmodule

// File: rtl/consensus_voter.sv
module consensus_voter
  import mv_pkg::*;
#(
  parameter int LANES      = 4,
  parameter int LANE_W     = 128,
  parameter int PAY_W      = 120,
  parameter int BEATS      = 4,
  parameter int CNT_WORD_W = 64,
  parameter int ADDR_W     = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    inValid,
  input  logic [LANES*LANE_W-1:0] inData,
  input  logic [CNT_WORD_W-1:0]   cntRdData,
  output logic [ADDR_W-1:0]       cntRdAddr,
  output logic                    outValid,
  output logic [PAY_W-1:0]        outCons,
  output logic [PAY_W-1:0]        outErase
);
  voteCtl_t ctl;

  mv_ctrl #(.BEATS(BEATS), .CNT_WORD_W(CNT_WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .cntRdData(cntRdData),
    .cntRdAddr(cntRdAddr),
    .ctl      (ctl)
  );

  mv_datapath #(.LANES(LANES), .LANE_W(LANE_W), .PAY_W(PAY_W), .BEATS(BEATS)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .inData  (inData),
    .ctl     (ctl),
    .outValid(outValid),
    .outCons (outCons),
    .outErase(outErase)
  );

  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |=> !outValid);

  p_out_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    outValid |-> $past(inValid));
endmodule

// File: tb/consensus_voter_test.sv
module consensus_voter_test;
  localparam int NROUNDS = 40;

  logic         clk = 0;
  logic         rst_n = 0;
  logic         inValid = 0;
  logic [511:0] inData = '0;
  logic [63:0]  cntRdData = '0;
  logic [9:0]   cntRdAddr;
  logic         outValid;
  logic [119:0] outCons, outErase;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [63:0]  ram [4];
  logic [119:0] qCons[$], qErase[$];
  string        qTag[$];
  int           qRound[$];
  logic [119:0] lastCons = '0, lastErase = '0;
  int pushed = 0, popped = 0;

  always #2 clk = ~clk;

  consensus_voter uut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inData(inData),
    .cntRdData(cntRdData), .cntRdAddr(cntRdAddr),
    .outValid(outValid), .outCons(outCons), .outErase(outErase)
  );

  // Count memory model with one cycle of read latency.
  always @(posedge clk) cntRdData <= ram[cntRdAddr[1:0]];

  function automatic logic [3:0] cntFor(int n);
    case (n)
      0: return 4'd5;
      1: return 4'd4;
      2: return 4'd0;
      3: return 4'd15;
      4: return 4'd1;
      5: return 4'd9;
      6: return 4'd2;
      default: return 4'((n * 5 + 3) % 16);
    endcase
  endfunction

  task automatic check(bit ok, string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [119:0] rnd120();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic runRound(int n);
    logic [119:0] slot [16];
    logic [119:0] eCons, eErase;
    int c;
    string tag;
    c = int'(cntFor(n));
    for (int s = 0; s < 16; s++) slot[s] = '0;
    if (n == 1) begin
      slot[0] = rnd120(); slot[1] = rnd120();
      slot[2] = ~slot[0]; slot[3] = ~slot[1];
      tag = "R4 tie";
    end else if (n == 2) tag = "R5 no copies";
    else if (n == 5) begin
      for (int s = 0; s < c; s++) slot[s] = '1;
      tag = "R3 all ones";
    end else if (n == 6) tag = "R7 clear after ones";
    else begin
      for (int s = 0; s < c; s++) slot[s] = rnd120();
      tag = (n >= 16) ? "R6 count field" : "R3 vote";
    end
    for (int i = 0; i < 120; i++) begin
      int ones = 0;
      for (int s = 0; s < 16; s++) ones += int'(slot[s][i]);
      eCons[i]  = (2 * ones > c);
      eErase[i] = (c == 0) || (2 * ones == c);
    end
    qCons.push_back(eCons); qErase.push_back(eErase);
    qTag.push_back(tag); qRound.push_back(n);
    pushed++;
    for (int b = 0; b < 4; b++) begin
      logic [511:0] w;
      for (int k = 0; k < 4; k++) begin
        w[k*128 +: 120] = slot[b*4 + k];
        w[k*128 + 120 +: 8] = 8'($urandom); // R1 padding noise
      end
      @(posedge clk); #1;
      inValid = 1; inData = w;
      if (n % 3 == 1 && b == 1) begin
        @(posedge clk); #1;
        inValid = 0; inData = {16{$urandom}};
        repeat (n % 4) @(posedge clk);
        #1;
      end
    end
    @(posedge clk); #1;
    inValid = 0; inData = {16{$urandom}};
    if (n % 4 == 2) begin
      repeat (2) @(posedge clk);
      #1;
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (outValid) begin
        if (qCons.size() == 0) check(0, "R2 extra outValid pulse", 128'(1), 128'(0));
        else begin
          logic [119:0] ec, ee;
          string t;
          int n;
          ec = qCons.pop_front(); ee = qErase.pop_front();
          t = qTag.pop_front(); n = qRound.pop_front();
          popped++;
          check(outCons == ec, {t, " R1 R3 consensus"}, 128'(outCons), 128'(ec));
          check(outErase == ee, {t, " R4 R5 erasure"}, 128'(outErase), 128'(ee));
          check(cntRdAddr == 10'(n / 16 + 1), "R6 address", 128'(cntRdAddr), 128'(n / 16 + 1));
          lastCons = outCons; lastErase = outErase;
        end
      end else if (popped > 0) begin
        check(outCons == lastCons && outErase == lastErase, "R9 hold",
              128'(outCons), 128'(lastCons));
      end
    end
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int f = 0; f < 16; f++) ram[w][f*4 +: 4] = cntFor(w * 16 + f);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(outValid == 0, "R8 outValid", 128'(outValid), 0);
    check(outCons == '0 && outErase == '0, "R8 outputs", 128'(outErase), 0);
    check(cntRdAddr == '0, "R8 address", 128'(cntRdAddr), 0);
    repeat (2) @(posedge clk);
    #1;
    for (int n = 0; n < NROUNDS; n++) runRound(n);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(popped == pushed && pushed == NROUNDS, "R2 round count",
          128'(popped), 128'(NROUNDS));
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule